// File: doc/BRIEF.md
# Paged register command interpreter

This block sits behind a byte-wide receive stream from a host and turns it into accesses on a local store of 24-bit words. Every transaction starts with one command byte. The two top bits of that byte pick one of four functions, and the low six bits are that function's argument. Register words are reached through a 12-bit address. The upper half of the address comes from a sticky page register, which a page-select command loads. The lower half comes from the read or write command itself.

A read sends the addressed word back on a byte-wide transmit stream as three bytes. A write gathers the three bytes that follow its command and stores them as one word. An instruction command is only unpacked: its six-bit code goes to an external dispatcher with a single-cycle strobe. Line framing and integrity checks belong to neighbouring blocks.

Top module: `paged_cmd_engine`

## Requirements
- R1: Bits [7:6] of a command byte select the function: 2'b00 read, 2'b01 write, 2'b10 page select, 2'b11 instruction.
- R2: A page-select command loads bits [5:0] into the page register and produces no transmit byte. The page stays in force for every later read and write until the next page select.
- R3: A read or write touches the word at address {page, command[5:0]}. Distinct pages with the same in-page offset hold distinct words, including page 0 offset 0 and page 63 offset 63.
- R4: A read command yields exactly three transmit bytes: word bits [23:16], then [15:8], then [7:0]. No byte appears without a read command.
- R5: A write command is followed by three received bytes, most significant first. The word is committed only when the third byte is accepted.
- R6: An instruction command raises instr_stb for exactly one cycle, in the cycle after the byte is accepted, with instr_code equal to command[5:0]. It produces no transmit byte and leaves the page unchanged.
- R7: in_ready is low from the acceptance of a read command until its third byte has been taken.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable.
- R9: An abort cycle returns the parser to command wait. The next clock drops any pending response and discards any partly received write. The page register is kept, and in_ready is low during the abort cycle.
- R10: After reset, in_ready is high, out_valid and instr_stb are low, and the page is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Synchronous return to command wait |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | Received byte present |
| in_ready | output | 1 | Block accepts the received byte |
| out_data | output | 8 | Transmit byte |
| out_valid | output | 1 | Transmit byte present |
| out_ready | input | 1 | Consumer takes the transmit byte |
| instr_code | output | 6 | Instruction code for the dispatcher |
| instr_stb | output | 1 | One-cycle instruction strobe |

## Verification
Words with different values in every byte are written and read back, so a byte-order slip or a wrong byte count stands out. The same offset is used under different pages, and in the two corner pages, so an address formed without the page register, or with the halves swapped, returns the other word. Reads run both with a consumer that is always ready and with one that stalls on alternate cycles, which separates correct holding of a stalled byte from a byte that drops or repeats. Aborts are placed in the middle of a write and in the middle of a stalled response, and instructions are mixed in between accesses, to show that neither one touches stored data or the page.

// File: rtl/pce_pkg.sv
package pce_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_PAGE  = 2'b10,
      OP_INSTR = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      ST_CMD,
      ST_WDATA,
      ST_TX
   } st_e;
endpackage

// File: rtl/pce_reg_file.sv
module pce_reg_file #(
   parameter int ADDR_W = 12,
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pce_tx_serializer.sv
module pce_tx_serializer #(
   parameter int BYTE_W     = 8,
   parameter int DATA_BYTES = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         abort,
   input  logic                         start,
   input  logic [BYTE_W*DATA_BYTES-1:0] word,
   output logic [BYTE_W-1:0]            out_data,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic                         done
);
   localparam int WORD_W = BYTE_W * DATA_BYTES;
   localparam int IDX_W  = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_BYTES - 1);

   logic             busy;
   logic [IDX_W-1:0] idx;
   logic [BYTE_W-1:0] lanes [DATA_BYTES];

   // Most significant byte is lane 0
   for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
      assign lanes[g] = word[WORD_W-1-g*BYTE_W -: BYTE_W];
   end

   assign out_valid = busy;
   assign out_data  = lanes[idx];
   assign done      = busy && out_ready && (idx == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy && out_ready) begin
         if (idx == LAST) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pce_cmd_parser.sv
module pce_cmd_parser
   import pce_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int SEL_W      = 2,
   parameter int DATA_BYTES = 3
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 abort,
   input  logic [BYTE_W-1:0]                    in_data,
   input  logic                                 in_valid,
   output logic                                 in_ready,
   output logic                                 we,
   output logic [2*(BYTE_W-SEL_W)-1:0]          waddr,
   output logic [BYTE_W*DATA_BYTES-1:0]         wdata,
   output logic                                 re,
   output logic [2*(BYTE_W-SEL_W)-1:0]          raddr,
   input  logic                                 tx_done,
   output logic [BYTE_W-SEL_W-1:0]              instr_code,
   output logic                                 instr_stb
);
   localparam int FIELD_W = BYTE_W - SEL_W;
   localparam int WORD_W  = BYTE_W * DATA_BYTES;
   localparam int CNT_W   = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_BYTES - 1);

   st_e                state;
   logic [FIELD_W-1:0] page;
   logic [FIELD_W-1:0] ofs_q;
   logic [CNT_W-1:0]   cnt;
   logic [WORD_W-1:0]  acc;
   logic               hs;
   op_e                op;
   logic [FIELD_W-1:0] field;
   logic [WORD_W-1:0]  acc_next;

   assign op    = op_e'(in_data[BYTE_W-1 -: SEL_W]);
   assign field = in_data[FIELD_W-1:0];

   assign in_ready = (state != ST_TX) && !abort;
   assign hs       = in_valid && in_ready;

   // Shift the new byte in at the bottom; the first byte ends up on top
   generate
      if (DATA_BYTES > 1) begin : g_acc_shift
         assign acc_next = {acc[WORD_W-BYTE_W-1:0], in_data};
      end else begin : g_acc_single
         assign acc_next = in_data;
      end
   endgenerate

   assign re    = hs && (state == ST_CMD) && (op == OP_READ);
   assign raddr = {page, field};
   assign we    = hs && (state == ST_WDATA) && (cnt == LAST);
   assign waddr = {page, ofs_q};
   assign wdata = acc_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_CMD;
         page       <= '0;
         ofs_q      <= '0;
         cnt        <= '0;
         acc        <= '0;
         instr_stb  <= 1'b0;
         instr_code <= '0;
      end else begin
         instr_stb <= 1'b0;
         if (abort) begin
            state <= ST_CMD;
            cnt   <= '0;
         end else begin
            unique case (state)
               ST_CMD: begin
                  if (hs) begin
                     unique case (op)
                        OP_READ:  state <= ST_TX;
                        OP_WRITE: begin
                           ofs_q <= field;
                           cnt   <= '0;
                           state <= ST_WDATA;
                        end
                        OP_PAGE:  page <= field;
                        OP_INSTR: begin
                           instr_stb  <= 1'b1;
                           instr_code <= field;
                        end
                        default: ;
                     endcase
                  end
               end
               ST_WDATA: begin
                  if (hs) begin
                     acc <= acc_next;
                     if (cnt == LAST) begin
                        cnt   <= '0;
                        state <= ST_CMD;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_TX: begin
                  if (tx_done) state <= ST_CMD;
               end
               default: state <= ST_CMD;
            endcase
         end
      end
   end
endmodule

// File: rtl/paged_cmd_engine.sv
module paged_cmd_engine #(
   parameter int BYTE_W     = 8,
   parameter int SEL_W      = 2,
   parameter int DATA_BYTES = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    abort,
   input  logic [BYTE_W-1:0]       in_data,
   input  logic                    in_valid,
   output logic                    in_ready,
   output logic [BYTE_W-1:0]       out_data,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [BYTE_W-SEL_W-1:0] instr_code,
   output logic                    instr_stb
);
   localparam int FIELD_W = BYTE_W - SEL_W;
   localparam int ADDR_W  = 2 * FIELD_W;
   localparam int WORD_W  = BYTE_W * DATA_BYTES;

   generate
      if (SEL_W != 2) begin : g_bad_sel
         $error("SEL_W must be 2 to hold four functions");
      end
      if (FIELD_W < 1 || ADDR_W > 16) begin : g_bad_field
         $error("field width out of range");
      end
      if (DATA_BYTES < 1) begin : g_bad_bytes
         $error("DATA_BYTES must be at least 1");
      end
   endgenerate

   logic              we, re, tx_done;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [WORD_W-1:0] wdata, rdata;

   pce_cmd_parser #(
      .BYTE_W(BYTE_W), .SEL_W(SEL_W), .DATA_BYTES(DATA_BYTES)
   ) u_parser (
      .clk(clk), .rst_n(rst_n), .abort(abort),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .we(we), .waddr(waddr), .wdata(wdata),
      .re(re), .raddr(raddr), .tx_done(tx_done),
      .instr_code(instr_code), .instr_stb(instr_stb)
   );

   pce_reg_file #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W)
   ) u_store (
      .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
      .re(re), .raddr(raddr), .rdata(rdata)
   );

   pce_tx_serializer #(
      .BYTE_W(BYTE_W), .DATA_BYTES(DATA_BYTES)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .abort(abort), .start(re),
      .word(rdata), .out_data(out_data), .out_valid(out_valid),
      .out_ready(out_ready), .done(tx_done)
   );
endmodule

// File: rtl/pce_checker.sv
module pce_checker #(
   parameter int BYTE_W = 8,
   parameter int SEL_W  = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    abort,
   input logic [BYTE_W-1:0]       in_data,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic [BYTE_W-1:0]       out_data,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [BYTE_W-SEL_W-1:0] instr_code,
   input logic                    instr_stb
);
   localparam int FIELD_W = BYTE_W - SEL_W;

   logic accept;
   assign accept = in_valid && in_ready;

   // R7
   tx_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !abort) |=> (out_valid && $stable(out_data)));

   // R9
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!out_valid && !instr_stb));

   // R9
   abort_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> !in_ready);

   // R6
   instr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_stb |-> ($past(accept && in_data[BYTE_W-1 -: SEL_W] == 2'b11)
                     && instr_code == $past(in_data[FIELD_W-1:0])));

   // R2
   page_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_data[BYTE_W-1 -: SEL_W] == 2'b10) |=> !out_valid);

   // R4
   resp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(accept && in_data[BYTE_W-1 -: SEL_W] == 2'b00));
endmodule

bind paged_cmd_engine pce_checker #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .abort(abort), .in_data(in_data),
   .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
   .out_valid(out_valid), .out_ready(out_ready),
   .instr_code(instr_code), .instr_stb(instr_stb)
);

// File: tb/paged_cmd_engine_bench.sv
`timescale 1ns/1ps
module paged_cmd_engine_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       abort = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] out_data;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [5:0] instr_code;
   logic       instr_stb;

   int checks = 0;
   int fails  = 0;
   int rdy_mode = 0;          // 0 always ready, 1 alternate, 2 never
   logic [5:0]  cur_page = '0;
   logic [23:0] model [4096];
   logic [7:0]  exp_q [$];
   bit          hold_pending = 0;
   logic [7:0]  held;

   always #2.5 clk = ~clk;

   paged_cmd_engine u_paged_cmd_engine (
      .clk(clk), .rst_n(rst_n), .abort(abort), .in_data(in_data),
      .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
      .out_valid(out_valid), .out_ready(out_ready),
      .instr_code(instr_code), .instr_stb(instr_stb)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // consumer readiness, driven just after each rising edge
   initial begin
      forever begin
         @(posedge clk); #1;
         case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = ~out_ready;
            default: out_ready = 1'b0;
         endcase
      end
   end

   // monitor: pops expected bytes on each transmit handshake
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) chk(!in_ready, "R7 in_ready during response", in_ready, 0);
         if (hold_pending) begin
            chk(out_valid && out_data == held, "R8 stalled byte held", out_data, held);
            hold_pending = 0;
         end
         if (out_valid && !out_ready && !abort) begin
            hold_pending = 1;
            held = out_data;
         end
         if (out_valid && out_ready && !abort) begin
            if (exp_q.size() == 0) chk(0, "R4 unexpected byte", out_data, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(out_data == e, "R4 response byte", out_data, e);
            end
         end
      end
   end

   task automatic send_byte(input logic [7:0] b);
      bit r;
      in_data  = b;
      in_valid = 1'b1;
      do begin
         @(negedge clk);
         r = in_ready;
         @(posedge clk); #1;
      end while (!r);
      in_valid = 1'b0;
   endtask

   task automatic sel_page(input logic [5:0] p);
      send_byte({2'b10, p});
      cur_page = p;
   endtask

   task automatic wr(input logic [5:0] ofs, input logic [23:0] v);
      send_byte({2'b01, ofs});
      send_byte(v[23:16]);
      send_byte(v[15:8]);
      send_byte(v[7:0]);
      model[{cur_page, ofs}] = v;
   endtask

   task automatic rd(input logic [5:0] ofs);
      logic [23:0] v;
      v = model[{cur_page, ofs}];
      exp_q.push_back(v[23:16]);
      exp_q.push_back(v[15:8]);
      exp_q.push_back(v[7:0]);
      send_byte({2'b00, ofs});
      while (exp_q.size() != 0) @(posedge clk);
      #1;
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic abort_pulse();
      abort = 1'b1;
      @(negedge clk);
      chk(!in_ready, "R9 in_ready low in abort cycle", in_ready, 0);
      @(posedge clk); #1;
      abort = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready === 1'b1, "R10 in_ready after reset", in_ready, 1);
      chk(out_valid === 1'b0, "R10 out_valid after reset", out_valid, 0);
      chk(instr_stb === 1'b0, "R10 instr_stb after reset", instr_stb, 0);
      @(posedge clk); #1;

      // R10 / R2 / R3: reset page is 0; same offset in two pages
      wr(6'd5, 24'hA1B2C3);
      sel_page(6'd1);
      wr(6'd5, 24'h3C2B1A);
      sel_page(6'd0);
      rd(6'd5);
      sel_page(6'd1);
      rd(6'd5);

      // R3: corner pages and offsets
      sel_page(6'd63);
      wr(6'd63, 24'hFF00F0);
      sel_page(6'd0);
      wr(6'd0, 24'h0F0F01);
      rd(6'd0);
      sel_page(6'd63);
      rd(6'd63);

      // R2: page select sends nothing
      sel_page(6'd7);
      repeat (4) begin
         @(negedge clk);
         chk(!out_valid, "R2 no response to page select", out_valid, 0);
      end
      @(posedge clk); #1;

      // R2 sticky page over several accesses; R5 commit ordering
      wr(6'd1, 24'h123456);
      wr(6'd2, 24'h789ABC);
      wr(6'd1, 24'hDEF012);
      rd(6'd1);
      rd(6'd2);

      // R6: instruction strobe and code, page kept
      send_byte({2'b11, 6'h2A});
      chk(instr_stb && instr_code == 6'h2A, "R6 strobe with code", {instr_stb, instr_code}, {1'b1, 6'h2A});
      chk(!out_valid, "R6 no response to instruction", out_valid, 0);
      @(posedge clk); #1;
      chk(!instr_stb, "R6 strobe one cycle", instr_stb, 0);
      send_byte({2'b11, 6'h01});
      send_byte({2'b11, 6'h3F});
      chk(instr_stb && instr_code == 6'h3F, "R6 back-to-back code", instr_code, 6'h3F);
      @(posedge clk); #1;
      rd(6'd2);   // R6 page still 7

      // R8: stalled consumer
      rdy_mode = 1;
      rd(6'd1);
      rd(6'd2);
      rdy_mode = 0;

      // R9: abort in middle of a write keeps old word
      sel_page(6'd3);
      wr(6'd10, 24'h55AA33);
      send_byte({2'b01, 6'd10});
      send_byte(8'h11);
      send_byte(8'h22);
      abort_pulse();
      rd(6'd10);
      // R1: next byte is read as a command again
      wr(6'd11, 24'h0BADF0);
      rd(6'd11);

      // R9: abort while a response is stalled
      rdy_mode = 2;
      @(posedge clk); #1;
      send_byte({2'b00, 6'd10});
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid, "R4 response pending", out_valid, 1);
      @(posedge clk); #1;
      abort_pulse();
      @(negedge clk);
      chk(!out_valid, "R9 response dropped", out_valid, 0);
      chk(in_ready, "R9 back to command wait", in_ready, 1);
      exp_q.delete();
      @(posedge clk); #1;
      rdy_mode = 0;
      @(posedge clk); #1;
      rd(6'd10);  // R9 page kept at 3

      // R1: all four functions in one sequence
      sel_page(6'd42);
      send_byte({2'b11, 6'h15});
      wr(6'd33, 24'h808182);
      rd(6'd33);

      repeat (5) @(posedge clk);
      chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule